// File: doc/BRIEF.md
# Read-Guarded Interrupt Status Flag Bank

This block holds a small set of interrupt status flags for a timer peripheral. Each flag records that a source event fired while its enable bit was set. The flags sit behind a simple register bus with read strobe, write strobe, address, write data and read data. The block drives one combined interrupt request.

Software clears a flag by writing 0 to its bit, but only if the last read of the status register returned 1 for that bit. An event that lands between the read and the clearing write therefore survives the write. A data-transfer controller can also clear any flag through a dedicated per-flag auto-clear input.

Each flag is a three-state machine:
- `FL_IDLE`: the flag is 0.
- `FL_PEND_NEW`: the flag is 1 and has not been read as 1.
- `FL_PEND_SEEN`: the flag is 1 and was read as 1 since the last status write.

The transitions are:
- **raise**: from any state when an enabled event fires. The target is `FL_PEND_NEW`, or it stays `FL_PEND_SEEN` when no write or auto-clear coincides.
- **observe**: `FL_PEND_NEW` to `FL_PEND_SEEN` on a status read.
- **acknowledge**: `FL_PEND_SEEN` to `FL_IDLE` on a status write of 0.
- **consume**: `FL_PEND_SEEN` to `FL_PEND_NEW` on a status write of 1.
- **drain**: any state to `FL_IDLE` on auto-clear.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset, all flags, all enable bits and `irq` are 0.
- R2: A flag becomes 1 at the clock edge where its `src_evt` bit is 1 and its enable bit is 1. An event with the enable bit at 0 does not set the flag.
- R3: A write to the status register (address 0) with bit i = 0 clears flag i if the most recent status read returned 1 in bit i.
- R4: A status write of 0 to a flag that has not been read as 1 since the last status write leaves the flag at 1.
- R5: A flag that rises after a status read returned 0 for it stays 1 through the next status write of 0.
- R6: Writing 1 to a status bit never changes that flag.
- R7: A 1 on `xfer_clr[i]` clears flag i at the next edge.
- R8: When a set event coincides with a permitted software clear or an auto-clear, the flag ends at 1.
- R9: `irq` is 1 exactly when some flag is 1 and its enable bit is 1.
- R10: Address 1 reads and writes the enable register. Addresses 2 and 3 read as 0, and writes to them change nothing.
- R11: Every status write consumes the read history. After read-1, write-1, write-0 with no read in between, the flag is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe; a status read records the flag values as seen |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address: 0 is status, 1 is enable |
| bus_wdata | input | NUM_FLAGS | Write data |
| bus_rdata | output | NUM_FLAGS | Read data, combinational from `bus_addr` |
| src_evt | input | NUM_FLAGS | Per-flag source event pulses |
| xfer_clr | input | NUM_FLAGS | Per-flag auto-clear from the transfer controller |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a flag rising in the gap between a status read that returned 0 and the following write of 0. The same applies to a set event on exactly the edge of a permitted clear. Directed sequences place a read, then an event pulse, then the clearing write on consecutive cycles. They also put an event and a clear in one cycle. A long randomized sweep then mixes reads, writes to all four addresses, events and auto-clears at high density, so these collisions happen hundreds of times. Each cycle's status and interrupt are compared with a bench model built from the requirements.

// File: rtl/isf_pkg.sv
package isf_pkg;
    typedef enum logic [1:0] {
        FL_IDLE      = 2'd0,
        FL_PEND_NEW  = 2'd1,
        FL_PEND_SEEN = 2'd2
    } flag_state_e;

    localparam int unsigned REG_STATUS = 0;
    localparam int unsigned REG_ENABLE = 1;
endpackage

// File: rtl/isf_decode.sv
module isf_decode #(
    parameter int unsigned NUM_FLAGS = 4,
    parameter int unsigned ADDR_W    = 2
) (
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [NUM_FLAGS-1:0] enables,
    output logic                 stat_rd,
    output logic                 stat_wr,
    output logic                 en_wr,
    output logic [NUM_FLAGS-1:0] rdata
);
    import isf_pkg::*;

    logic hit_status;
    logic hit_enable;

    always_comb begin
        hit_status = (bus_addr == ADDR_W'(REG_STATUS));
        hit_enable = (bus_addr == ADDR_W'(REG_ENABLE));
        stat_rd    = bus_rd && hit_status;
        stat_wr    = bus_wr && hit_status;
        en_wr      = bus_wr && hit_enable;
        if (hit_status)      rdata = flags;
        else if (hit_enable) rdata = enables;
        else                 rdata = '0;
    end
endmodule

// File: rtl/isf_flag_cell.sv
module isf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic auto_clr,
    input  logic stat_rd,
    input  logic stat_wr,
    input  logic wr_bit,
    output logic flag_o
);
    import isf_pkg::*;

    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (set_evt) begin
            // raise: stays seen only when nothing consumes or drains the history
            if (!stat_wr && !auto_clr && state_q != FL_IDLE &&
                (state_q == FL_PEND_SEEN || stat_rd))
                state_d = FL_PEND_SEEN;
            else
                state_d = FL_PEND_NEW;
        end else if (auto_clr) begin
            state_d = FL_IDLE;                       // drain
        end else begin
            unique case (state_q)
                FL_IDLE:      state_d = FL_IDLE;
                FL_PEND_NEW: begin
                    if (stat_wr)      state_d = FL_PEND_NEW;
                    else if (stat_rd) state_d = FL_PEND_SEEN;   // observe
                end
                FL_PEND_SEEN: begin
                    if (stat_wr)
                        state_d = wr_bit ? FL_PEND_NEW : FL_IDLE; // consume / acknowledge
                end
                default:      state_d = FL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_o = (state_q != FL_IDLE);
    end

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_o);
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !set_evt) |=> !flag_o);
    p_clear_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_PEND_SEEN && stat_wr && !wr_bit && !set_evt && !auto_clr) |=> !flag_o);
    p_keep_unseen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_PEND_NEW && !auto_clr) |=> flag_o);
    p_write_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && stat_wr && wr_bit && !auto_clr) |=> flag_o);
    p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_clr && !set_evt) |=> !flag_o);
    p_consume_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (state_q != FL_PEND_SEEN));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned NUM_FLAGS = 4,
    parameter int unsigned ADDR_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_FLAGS-1:0] bus_wdata,
    output logic [NUM_FLAGS-1:0] bus_rdata,
    input  logic [NUM_FLAGS-1:0] src_evt,
    input  logic [NUM_FLAGS-1:0] xfer_clr,
    output logic                 irq
);
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] en_q;
    logic                 stat_rd, stat_wr, en_wr;

    isf_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec (
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .flags   (flags),
        .enables (en_q),
        .stat_rd (stat_rd),
        .stat_wr (stat_wr),
        .en_wr   (en_wr),
        .rdata   (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= bus_wdata;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        isf_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (src_evt[i] && en_q[i]),
            .auto_clr(xfer_clr[i]),
            .stat_rd (stat_rd),
            .stat_wr (stat_wr),
            .wr_bit  (bus_wdata[i]),
            .flag_o  (flags[i])
        );
    end

    always_comb begin
        irq = |(flags & en_q);
    end

    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_q != '0));
    p_reset_clean_r1: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && en_q == '0));
    p_enable_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_q == $past(bus_wdata)));
endmodule

// File: tb/tb_irq_flag_bank.sv
module tb_irq_flag_bank;
    localparam int NF = 4;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_rd = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [NF-1:0] bus_wdata = '0, bus_rdata, src_evt = '0, xfer_clr = '0;
    logic          irq;

    int tests = 0, fails = 0;
    logic [NF-1:0] last_rd;
    logic [NF-1:0] pv;

    irq_flag_bank #(.NUM_FLAGS(NF), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_evt(src_evt), .xfer_clr(xfer_clr), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [NF-1:0] got, input logic [NF-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic cyc(input logic rd, input logic wr, input logic [AW-1:0] a,
                       input logic [NF-1:0] wd, input logic [NF-1:0] ev, input logic [NF-1:0] cl);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; src_evt = ev; xfer_clr = cl;
        #1 last_rd = bus_rdata;
        @(posedge clk);
        #1;
        bus_rd = 0; bus_wr = 0; bus_wdata = '0; src_evt = '0; xfer_clr = '0;
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [NF-1:0] d);
        bus_rd = 0; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [NF-1:0] m_flag, m_seen, m_en;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        peek(0, pv); check("R1 status", pv, '0);
        peek(1, pv); check("R1 enable", pv, '0);
        check("R1 irq", {3'b0, irq}, '0);

        cyc(0, 1, 1, 4'b1010, 0, 0);
        peek(1, pv); check("R10 enable rw", pv, 4'b1010);
        cyc(0, 1, 2, 4'b1111, 0, 0);
        cyc(0, 1, 3, 4'b1111, 0, 0);
        peek(2, pv); check("R10 addr2 reads 0", pv, '0);
        peek(1, pv); check("R10 unused write ignored", pv, 4'b1010);

        cyc(0, 0, 0, 0, 4'b1111, 0);
        peek(0, pv); check("R2 set gated by enable", pv, 4'b1010);
        check("R9 irq high", {3'b0, irq}, 4'b0001);

        cyc(0, 1, 0, 4'b0000, 0, 0);
        peek(0, pv); check("R4 unread write0 keeps", pv, 4'b1010);

        cyc(1, 0, 0, 0, 0, 0);
        check("R3 read value", last_rd, 4'b1010);
        cyc(0, 1, 0, 4'b0000, 0, 0);
        peek(0, pv); check("R3 clear after read1", pv, 4'b0000);
        check("R9 irq low", {3'b0, irq}, '0);

        cyc(0, 1, 1, 4'b1111, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        check("R5 read zero", last_rd, 4'b0000);
        cyc(0, 0, 0, 0, 4'b0001, 0);
        cyc(0, 1, 0, 4'b0000, 0, 0);
        peek(0, pv); check("R5 late event survives", pv, 4'b0001);

        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 4'b1111, 0, 0);
        peek(0, pv); check("R6 write1 no effect", pv, 4'b0001);
        cyc(0, 1, 0, 4'b0000, 0, 0);
        peek(0, pv); check("R11 history consumed", pv, 4'b0001);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 4'b0000, 0, 0);
        peek(0, pv); check("R3 clear after fresh read", pv, 4'b0000);

        cyc(0, 0, 0, 0, 4'b0100, 0);
        cyc(0, 0, 0, 0, 0, 4'b0100);
        peek(0, pv); check("R7 auto clear", pv, 4'b0000);

        cyc(0, 0, 0, 0, 4'b0010, 0);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 4'b0000, 4'b0010, 0);
        peek(0, pv); check("R8 set beats sw clear", pv, 4'b0010);
        cyc(0, 0, 0, 0, 4'b1000, 4'b1000);
        peek(0, pv); check("R8 set beats auto clear", pv, 4'b1010);

        cyc(0, 1, 1, 4'b0000, 0, 0);
        check("R9 masked irq", {3'b0, irq}, '0);
        peek(0, pv); check("R9 flags kept when masked", pv, 4'b1010);

        m_flag = 4'b1010; m_seen = '0; m_en = '0;
        for (int n = 0; n < 3000; n++) begin
            logic rd, wr; logic [AW-1:0] a; logic [NF-1:0] wd, ev, cl, setv, clrv, f_n;
            rd = ($urandom % 3) == 0;
            wr = ($urandom % 3) == 0;
            a  = AW'($urandom % 4);
            if (($urandom % 3) != 0) a = 0;
            wd = NF'($urandom);
            ev = NF'($urandom) & NF'($urandom);
            cl = NF'($urandom) & NF'($urandom) & NF'($urandom);
            cyc(rd, wr, a, wd, ev, cl);
            setv = ev & m_en;
            clrv = cl | ((wr && a == 0) ? (~wd & m_seen) : '0);
            f_n  = setv | (m_flag & ~clrv);
            m_seen = f_n & m_flag & ~cl & ((wr && a == 0) ? '0 : (m_seen | ((rd && a == 0) ? '1 : '0)));
            m_flag = f_n;
            if (wr && a == 1) m_en = wd;
            peek(0, pv); check("R2 R3 R4 R5 R8 R11 sweep status", pv, m_flag);
            peek(1, pv); check("R10 sweep enable", pv, m_en);
            check("R9 sweep irq", {3'b0, irq}, {3'b0, |(m_flag & m_en)});
        end

        rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        peek(0, pv); check("R1 reset again status", pv, '0);
        peek(1, pv); check("R1 reset again enable", pv, '0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule